// File: doc/BRIEF.md
# Serial NOR Flash Target Emulator

This block is an SPI slave that behaves like a small serial NOR flash. It lets a flash master controller be tested against a realistic target without a real part. It samples the serial clock, chip select and data-in lines in its own system clock domain and decodes one command per chip-select frame. It drives the data-out line and holds a byte-wide memory array. Supported commands are write enable, status read, data read, sector erase and page program.

Program data is collected into a page-sized staging buffer while the frame is open. Programming or erasing starts only when chip select returns high. A countdown then holds the write-in-progress flag for a parameterized number of clock cycles. During that time a walker applies the operation to the array one byte per cycle. Programming can only clear bits. Erasing restores a whole sector to all ones.

Top module: `flash_emu`

## Requirements
- R1: The serial link uses SPI mode 0. Data-in is captured on the rising serial clock edge and data-out changes on the falling edge, most significant bit first. Opcodes are 0x06 write enable, 0x05 status read, 0x03 read, 0x20 sector erase and 0x02 page program. Status read returns status bytes until chip select rises: bit 0 is write-in-progress, bit 1 is the write-enable latch, and the other bits are 0.
- R2: A write-enable frame sets the write-enable latch when chip select rises, so a following status read returns 0x02.
- R3: A read command is followed by three address bytes, most significant first; only the low log2(MEM_BYTES) bits are used. The output during the opcode and address bytes is don't-care. Each further byte returns consecutive memory contents, and the address wraps from the top of memory to 0.
- R4: With the latch set, page program data bytes are placed at the addressed offset plus n, taken modulo PAGE_BYTES, within the addressed page. The array changes only after chip select rises, as old value AND data. Offsets that received no byte keep their value.
- R5: When more than PAGE_BYTES data bytes are sent in one program frame, only the last PAGE_BYTES bytes are programmed.
- R6: With the latch set, a sector erase makes every byte of the SECTOR_BYTES-aligned sector that holds the address read 0xFF. Other sectors are left unchanged.
- R7: Write-in-progress reads 1 from the chip-select rise that starts a program (for PROG_CYCLES cycles) or an erase (for ERASE_CYCLES cycles). Afterwards it reads 0 and the write-enable latch is clear.
- R8: A program or erase sent while the latch is clear does nothing. So does a frame that ends before all three address bytes arrive, or a program frame with no data byte. In each of these cases the status is left unchanged.
- R9: While write-in-progress is set, every command except status read is ignored and the data-out line returns 0xFF bytes.
- R10: Only the first byte after chip select falls is decoded as an opcode. A program opcode sent as a later byte has no effect on memory or status.
- R11: After reset the status reads 0x00 and every memory byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing one command |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The bench builds the block with a 256-byte memory, 32-byte pages, 64-byte sectors, a 1500-cycle program time and a 2500-cycle erase time. At this size every memory byte can be read back after each group of operations and compared with a model held in the bench. The small page makes the in-page wrap and the keep-the-last-page rule reachable with frames of only a few dozen bytes. Busy times that are short but much longer than one status frame allow the flag to be polled both near the end of the busy window and after it.

// File: rtl/flash_emu_pkg.sv
// Shared opcodes and state encodings for the serial flash emulator.
// Assumes byte-wide commands with a 24-bit address phase.
package flash_emu_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_PP   = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_STAT, ST_WREN, ST_IGN
    } frame_st_t;

    typedef enum logic [1:0] {
        CMD_NONE, CMD_READ, CMD_PP, CMD_SE
    } cmd_t;
endpackage

// File: rtl/flash_emu_spi_if.sv
// Mode-0 SPI slave front end: synchronises the serial lines into clk,
// assembles received bytes and shifts out the byte offered on tx_data.
// Assumes clk runs at least 8x the serial clock; tx_data must be valid
// before the falling edge that follows each completed byte.
module flash_emu_spi_if #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_data,
    output logic       miso,
    output logic       frame_start,
    output logic       frame_end,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
    logic rise, fall;
    logic [2:0] bitcnt;
    logic [7:0] rx_sh, tx_sh;

    assign sclk_s = sclk_q[SYNC_STAGES-1];
    assign cs_s   = cs_q[SYNC_STAGES-1];
    assign mosi_s = mosi_q[SYNC_STAGES-1];
    assign rise   = sclk_s & ~sclk_d;
    assign fall   = ~sclk_s & sclk_d;
    assign miso   = tx_sh[7];

    // Synchronise the serial inputs and keep one delayed copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    // Frame boundary pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
        end else begin
            frame_start <= ~cs_s & cs_d;
            frame_end   <= cs_s & ~cs_d;
        end
    end

    // Receive shifter: one byte pulse per eight rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            bitcnt     <= '0;
            rx_sh      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else if (rise) begin
            rx_sh      <= {rx_sh[6:0], mosi_s};
            bitcnt     <= bitcnt + 3'd1;
            byte_valid <= (bitcnt == 3'd7);
            byte_data  <= {rx_sh[6:0], mosi_s};
        end else begin
            byte_valid <= 1'b0;
        end
    end

    // Transmit shifter: loads a new byte on the falling edge at a byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            tx_sh <= 8'hFF;
        end else if (fall) begin
            tx_sh <= (bitcnt == 3'd0) ? tx_data : {tx_sh[6:0], 1'b1};
        end
    end

    // A byte boundary falling edge presents the offered byte's MSB.
    assert_tx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bitcnt == 3'd0 && !cs_s) |=> (miso == $past(tx_data[7])));
endmodule

// File: rtl/flash_emu_busy_timer.sv
// Countdown that holds the busy flag for a loaded number of cycles.
// Assumes start is only raised while idle.
module flash_emu_busy_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= load;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/flash_emu_page_buf.sv
// Page staging buffer: ring-indexed byte store with per-byte valid flags.
// Unwritten bytes read as 0xFF so they leave cells untouched on AND.
module flash_emu_page_buf #(
    parameter int PAGE_BYTES = 256,
    localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_mask
);
    logic [7:0]            data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;

    assign rd_mask = valid[rd_idx] ? data[rd_idx] : 8'hFF;

    // Store staged data; later writes to the same slot overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (we) data[wr_idx] <= wr_data;
    end

    // Track which slots hold staged data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid <= '0;
        else if (we)       valid[wr_idx] <= 1'b1;
    end

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid == '0));
endmodule

// File: rtl/flash_emu_cell_array.sv
// Byte memory array with one synchronous write port and an async read port.
// Resets every byte to the erased value 0xFF.
module flash_emu_cell_array #(
    parameter int MEM_BYTES = 1024,
    localparam int ADDR_W = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [MEM_BYTES];

    assign rdata = mem[addr];

    // Reset to erased state, otherwise write one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/flash_emu.sv
// Serial NOR flash emulator top: decodes one command per chip-select frame,
// stages program data, and applies program/erase after chip select rises
// while a timer holds write-in-progress. Assumes SECTOR_BYTES >= PAGE_BYTES
// and MEM_BYTES a power of two no larger than 2^24.
module flash_emu
    import flash_emu_pkg::*;
#(
    parameter int MEM_BYTES    = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 512,
    parameter int PROG_CYCLES  = 1000,
    parameter int ERASE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int ADDR_W    = $clog2(MEM_BYTES);
    localparam int PAGE_W    = $clog2(PAGE_BYTES);
    localparam int WALK_W    = $clog2(SECTOR_BYTES) + 1;
    localparam int PROG_LEN  = (PROG_CYCLES  > PAGE_BYTES)   ? PROG_CYCLES  : PAGE_BYTES;
    localparam int ERASE_LEN = (ERASE_CYCLES > SECTOR_BYTES) ? ERASE_CYCLES : SECTOR_BYTES;
    localparam int MAX_LEN   = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
    localparam int TMR_W     = $clog2(MAX_LEN + 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_BYTES - 1);

    logic frame_start, frame_end, byte_valid;
    logic [7:0] byte_data, tx_data;
    frame_st_t st;
    cmd_t cmd;
    logic [1:0] addr_cnt;
    logic [ADDR_W-1:0] addr_sh, op_addr, rd_ptr, new_addr;
    logic fetch, got_data, wel;
    logic [PAGE_W-1:0] pb_idx;
    logic busy, done, start_pp, start_se, pb_clr, pb_we;
    logic walking, walk_erase;
    logic [WALK_W-1:0] walk_idx, walk_last;
    logic [ADDR_W-1:0] walk_base, mem_addr;
    logic [7:0] mem_rdata, mem_wdata, pb_mask;

    flash_emu_spi_if #(.SYNC_STAGES(2)) u_spi (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .tx_data(tx_data), .miso(spi_miso),
        .frame_start(frame_start), .frame_end(frame_end),
        .byte_valid(byte_valid), .byte_data(byte_data)
    );

    assign new_addr = ADDR_W'({addr_sh, byte_data});
    assign start_pp = frame_end && st == ST_DATA && cmd == CMD_PP && got_data;
    assign start_se = frame_end && st == ST_DATA && cmd == CMD_SE;
    assign pb_clr   = byte_valid && st == ST_OPC && !busy && wel && byte_data == OP_PP;
    assign pb_we    = byte_valid && st == ST_DATA && cmd == CMD_PP;

    flash_emu_busy_timer #(.CNT_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_pp || start_se),
        .load(start_se ? TMR_W'(ERASE_LEN) : TMR_W'(PROG_LEN)),
        .busy(busy), .done(done)
    );

    flash_emu_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .wr_idx(pb_idx), .wr_data(byte_data),
        .rd_idx(PAGE_W'(walk_idx)), .rd_mask(pb_mask)
    );

    assign mem_addr  = walking ? (walk_base | ADDR_W'(walk_idx)) : rd_ptr;
    assign mem_wdata = walk_erase ? 8'hFF : (mem_rdata & pb_mask);

    flash_emu_cell_array #(.MEM_BYTES(MEM_BYTES)) u_cells (
        .clk(clk), .rst_n(rst_n), .we(walking), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // Frame decoder: opcode, address and data phases plus the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cmd <= CMD_NONE; addr_cnt <= '0; addr_sh <= '0;
            op_addr <= '0; rd_ptr <= '0; fetch <= 1'b0; got_data <= 1'b0;
            pb_idx <= '0; tx_data <= 8'hFF;
        end else if (frame_start) begin
            st <= ST_OPC; cmd <= CMD_NONE; addr_cnt <= '0;
            fetch <= 1'b0; got_data <= 1'b0; tx_data <= 8'hFF;
        end else if (frame_end) begin
            st <= ST_IDLE;
        end else if (fetch) begin
            tx_data <= mem_rdata;
            rd_ptr  <= rd_ptr + ADDR_W'(1);
            fetch   <= 1'b0;
        end else if (st == ST_STAT) begin
            tx_data <= {6'b0, wel, busy};
        end else if (byte_valid) begin
            case (st)
                ST_OPC: begin
                    if (busy) begin
                        st <= (byte_data == OP_RDSR) ? ST_STAT : ST_IGN;
                    end else begin
                        case (byte_data)
                            OP_WREN: st <= ST_WREN;
                            OP_RDSR: st <= ST_STAT;
                            OP_READ: begin st <= ST_ADDR; cmd <= CMD_READ; end
                            OP_PP:   begin st <= wel ? ST_ADDR : ST_IGN; cmd <= CMD_PP; end
                            OP_SE:   begin st <= wel ? ST_ADDR : ST_IGN; cmd <= CMD_SE; end
                            default: st <= ST_IGN;
                        endcase
                    end
                end
                ST_ADDR: begin
                    addr_sh  <= new_addr;
                    addr_cnt <= addr_cnt + 2'd1;
                    if (addr_cnt == 2'd2) begin
                        st      <= ST_DATA;
                        op_addr <= new_addr;
                        rd_ptr  <= new_addr;
                        pb_idx  <= PAGE_W'(new_addr);
                        fetch   <= (cmd == CMD_READ);
                    end
                end
                ST_DATA: begin
                    if (cmd == CMD_READ) fetch <= 1'b1;
                    if (cmd == CMD_PP) begin
                        got_data <= 1'b1;
                        pb_idx   <= pb_idx + PAGE_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Write-enable latch: set at the end of a write-enable frame, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wel <= 1'b0;
        else if (done)                       wel <= 1'b0;
        else if (frame_end && st == ST_WREN) wel <= 1'b1;
    end

    // Walker: applies the staged page or the erase one byte per cycle.
    assign walk_last = walk_erase ? WALK_W'(SECTOR_BYTES - 1) : WALK_W'(PAGE_BYTES - 1);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking <= 1'b0; walk_erase <= 1'b0; walk_idx <= '0; walk_base <= '0;
        end else if (start_pp || start_se) begin
            walking    <= 1'b1;
            walk_erase <= start_se;
            walk_idx   <= '0;
            walk_base  <= start_se ? (op_addr & ~SECT_MASK) : (op_addr & ~PAGE_MASK);
        end else if (walking) begin
            walk_idx <= walk_idx + WALK_W'(1);
            if (walk_idx == walk_last) walking <= 1'b0;
        end
    end

    assert_walk_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        walking |-> busy);
    assert_wel_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel);
    assert_start_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pp || start_se) |-> (wel && !busy));
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_valid && st == ST_OPC) |=> (st == ST_STAT || st == ST_IGN));
endmodule

// File: tb/flash_emu_test.sv
`timescale 1ns/1ps
module flash_emu_test;
    localparam int MEM = 256, PAGE = 32, SECT = 64, PROG = 1500, ERASE = 2500;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] model [MEM];

    always #10 clk = ~clk;

    flash_emu #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT),
                .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso));

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(5);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(5);
            sclk = 1'b0;
        end
    endtask

    task automatic fbegin();
        cs_n = 1'b0; wait_clk(5);
    endtask

    task automatic fend();
        wait_clk(5); cs_n = 1'b1; wait_clk(8);
    endtask

    task automatic send_addr(input int a);
        logic [7:0] r;
        xfer(8'(a >> 16), r); xfer(8'(a >> 8), r); xfer(8'(a), r);
    endtask

    task automatic wren();
        logic [7:0] r;
        fbegin(); xfer(8'h06, r); fend();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        fbegin(); xfer(8'h05, r); xfer(8'h00, s); fend();
    endtask

    task automatic read_cmp(input int a, input int n, input string req);
        logic [7:0] r;
        fbegin(); xfer(8'h03, r); send_addr(a);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            check_eq(req, $sformatf("read @%0h", (a + i) % MEM), r, model[(a + i) % MEM]);
        end
        fend();
    endtask

    // Page program of n bytes (seed + i*mul); apply=1 updates the model.
    task automatic pp(input int a, input int n, input int seed, input int mul, input bit apply);
        logic [7:0] r, d;
        logic [7:0] pbuf [PAGE];
        int base, off;
        base = a - (a % PAGE); off = a % PAGE;
        for (int j = 0; j < PAGE; j++) pbuf[j] = 8'hFF;
        fbegin(); xfer(8'h02, r); send_addr(a);
        for (int i = 0; i < n; i++) begin
            d = 8'(seed + i * mul);
            xfer(d, r);
            pbuf[(off + i) % PAGE] = d;
        end
        fend();
        if (apply) for (int j = 0; j < PAGE; j++) model[base + j] = model[base + j] & pbuf[j];
    endtask

    task automatic erase(input int a, input bit apply);
        logic [7:0] r;
        int base;
        base = a - (a % SECT);
        fbegin(); xfer(8'h20, r); send_addr(a); fend();
        if (apply) for (int j = 0; j < SECT; j++) model[base + j] = 8'hFF;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait_clk(195000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r;
        for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
        wait_clk(5); rst_n = 1'b1; wait_clk(5);

        // R11: reset status and erased array
        rdsr(s); check_eq("R11", "status after reset", s, 8'h00);
        read_cmp(0, MEM, "R11");

        // R2: write enable
        wren(); rdsr(s); check_eq("R2", "status after wren", s, 8'h02);

        // R4 wrap inside page, R7 busy window
        pp(8'h1E, 4, 8'hA5, 8'h11, 1'b1);
        rdsr(s); check_eq("R7", "status at program start", s, 8'h03);
        wait_clk(PROG - 600);
        rdsr(s); check_eq("R7", "status near program end", s, 8'h03);
        wait_clk(400);
        rdsr(s); check_eq("R7", "status after program", s, 8'h00);
        read_cmp(0, PAGE, "R4");

        // R4: programming only clears bits
        wren(); pp(8'h1E, 4, 8'h0F, 8'h30, 1'b1); wait_clk(PROG + 200);
        read_cmp(0, PAGE, "R4");

        // R5: overlong frame keeps the last page of data
        wren(); pp(8'h45, PAGE + 8, 8'h01, 8'h07, 1'b1); wait_clk(PROG + 200);
        read_cmp(8'h40, PAGE, "R5");

        // R8: program without write enable
        pp(8'h60, 4, 8'h00, 8'h01, 1'b0);
        rdsr(s); check_eq("R8", "status after rejected program", s, 8'h00);
        read_cmp(8'h60, PAGE, "R8");

        // R8: erase frame with short address does nothing
        wren();
        fbegin(); xfer(8'h20, r); xfer(8'h00, r); xfer(8'h00, r); fend();
        rdsr(s); check_eq("R8", "status after short erase", s, 8'h02);
        read_cmp(0, 8, "R8");

        // R6: erase sector 0, sector 1 untouched
        erase(8'h05, 1'b1);
        rdsr(s); check_eq("R7", "status at erase start", s, 8'h03);
        wait_clk(ERASE + 200);
        rdsr(s); check_eq("R7", "status after erase", s, 8'h00);
        read_cmp(0, 2 * SECT, "R6");

        // R9: commands other than status read ignored while busy
        wren(); pp(8'h80, 3, 8'h12, 8'h01, 1'b1);
        fbegin(); xfer(8'h03, r); send_addr(8'h45);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, r); check_eq("R9", "read while busy", r, 8'hFF);
        end
        fend();
        erase(8'h40, 1'b0);
        wren();
        wait_clk(PROG + 200);
        rdsr(s); check_eq("R9", "status after busy commands", s, 8'h00);
        read_cmp(8'h40, SECT, "R9");

        // R10: program opcode not in first position
        wren();
        fbegin(); xfer(8'h00, r); xfer(8'h02, r); send_addr(8'hA0);
        xfer(8'h00, r); xfer(8'h00, r); fend();
        rdsr(s); check_eq("R10", "status after late opcode", s, 8'h02);
        read_cmp(8'hA0, 8, "R10");

        // R1: repeated status bytes in one frame
        fbegin(); xfer(8'h05, r);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, s); check_eq("R1", "repeated status", s, 8'h02);
        end
        fend();

        // R3: read wraps at the top of memory
        read_cmp(MEM - 4, 8, "R3");

        // R3 R4 R5 R6: full array compare
        read_cmp(0, MEM, "R3 R4 R5 R6");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule